// File: doc/BRIEF.md
# Programmable Square-Wave Generator

This block makes a square wave from a 32.768 kHz timekeeping reference. The reference reaches it as a one-cycle enable, `edge_tick`, in the fast system clock domain. The enable pulses once at every edge of the reference, which is 65 536 times a second, so each pulse marks one half period. A reference-phase flop toggles on every pulse and so reproduces the 32.768 kHz wave. A 15-bit binary count of the same pulses supplies the slower rates: bit k of the count has a frequency of 32768 / 2^k Hz and a 50% duty cycle.

A small mode machine picks the source from the control inputs:

| State | Meaning | Output |
|---|---|---|
| `SQ_DISABLED` | Main power is present and the output is switched off. | Low |
| `SQ_NO_RATE` | Divided mode was chosen with rate code 0. | Low |
| `SQ_REF` | Full-rate mode on main power. | Reference phase |
| `SQ_TAP` | Divided mode on main power. | Selected count bit |
| `SQ_BATT_REF` | Main power is absent and every backup condition holds. | Reference phase |
| `SQ_BATT_BLOCK` | Main power is absent and some backup condition is missing. | Low |

Every clock the machine moves to the state that the present inputs select. Any state can move to any other state, so no transition depends on the current state.

A three-bit run-control field starts and stops the counter. The 32.768 kHz path does not depend on that field.

Top module: `sqw_gen`

## Requirements
- R1: While `rst_n` is low, `sq_out` is 0, and the reference phase and the counter are cleared.
- R2: With `main_pwr`=1 and `out_en`=0, `sq_out` stays 0 whatever the other inputs are.
- R3: With `main_pwr`=1, `out_en`=1 and `full_rate`=1, `sq_out` is the reference phase. It toggles once for every `edge_tick` pulse, whatever the value of `rate_sel`.
- R4: With `main_pwr`=1, `out_en`=1, `full_rate`=0 and `rate_sel` nonzero, `sq_out` equals one bit of the counter. Code 1 selects bit 7 (256 Hz) and code 2 selects bit 8 (128 Hz). Codes 3 to 15 select bits 2 to 14, which run from 8192 Hz down to 2 Hz.
- R5: With `full_rate`=0 and `rate_sel`=0, `sq_out` stays 0 while main power is present.
- R6: The counter advances on `edge_tick` only when `run_ctl[2]`=0 and `run_ctl[1]`=1. `run_ctl[0]` has no effect. For any other pattern the counter is held at zero, so every divided output is low.
- R7: The reference phase toggles on every `edge_tick` whatever the value of `run_ctl`.
- R8: With `main_pwr`=0, `sq_out` is the reference phase only if `out_en`, `full_rate`, `aux_bat_en` and `aux_pwr` are all 1. Otherwise `sq_out` is 0.
- R9: A change on the mode inputs reaches `sq_out` at the second rising edge after the change. A change on `rate_sel` within divided mode, or a change of the counter or phase, reaches it at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_tick | input | 1 | One-cycle pulse at each edge of the 32.768 kHz reference |
| out_en | input | 1 | Square-wave output enable |
| full_rate | input | 1 | Selects the 32.768 kHz reference instead of a counter tap |
| rate_sel | input | 4 | Rate code for divided mode |
| run_ctl | input | 3 | Counter run control; the counter runs on pattern 01x |
| main_pwr | input | 1 | Main supply present |
| aux_bat_en | input | 1 | Allows output on auxiliary power |
| aux_pwr | input | 1 | Auxiliary supply present |
| sq_out | output | 1 | Square-wave output |

## Verification
The same rate code is applied first in full-rate mode and then in divided mode, which shows that `full_rate` overrides `rate_sel`. All fifteen nonzero codes are run in turn, and code 15 is held long enough to see a 2 Hz edge, so any wrong tap position stands out. The bench walks through all eight run-control patterns, which separates the stopped patterns from the running pattern and shows that the low run-control bit is ignored. With main power absent, each of the four backup conditions is removed one at a time while the other three stay set, so a gate that lacks any one term shows up.

// File: rtl/sqw_pkg.sv
`timescale 1ns/1ps
package sqw_pkg;

    typedef enum logic [2:0] {
        SQ_DISABLED   = 3'd0,
        SQ_NO_RATE    = 3'd1,
        SQ_REF        = 3'd2,
        SQ_TAP        = 3'd3,
        SQ_BATT_REF   = 3'd4,
        SQ_BATT_BLOCK = 3'd5
    } sq_state_e;

    // Counter bit driven out for a given rate code (code 0 unused).
    function automatic int unsigned tap_of_code(input int unsigned code);
        case (code)
            0:       return 0;
            1:       return 7;
            2:       return 8;
            default: return code - 1;
        endcase
    endfunction

endpackage

// File: rtl/sqw_ref_phase.sv
`timescale 1ns/1ps
module sqw_ref_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic phase_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_o <= 1'b0;
        else if (tick_i) phase_o <= ~phase_o;
    end
endmodule

// File: rtl/sqw_div_chain.sv
`timescale 1ns/1ps
module sqw_div_chain #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) count_o <= '0;
        else if (tick_i)      count_o <= count_o + ONE;
    end
endmodule

// File: rtl/sqw_tap_mux.sv
`timescale 1ns/1ps
module sqw_tap_mux #(
    parameter int CNT_W = 15,
    parameter int RS_W  = 4
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [RS_W-1:0]  code_i,
    output logic             tap_o
);
    localparam int N_CODES = 2 ** RS_W;

    logic [N_CODES-1:0] cand;
    logic               tap_unused_bits;

    assign tap_unused_bits = ^count_i;

    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        localparam int unsigned IDX = sqw_pkg::tap_of_code(g);
        if (g == 0 || IDX >= CNT_W) begin : g_none
            assign cand[g] = 1'b0;
        end else begin : g_tap
            assign cand[g] = count_i[IDX];
        end
    end

    assign tap_o = cand[code_i];
endmodule

// File: rtl/sqw_mode_fsm.sv
`timescale 1ns/1ps
module sqw_mode_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                out_en,
    input  logic                full_rate,
    input  logic                rate_zero,
    input  logic                main_pwr,
    input  logic                aux_bat_en,
    input  logic                aux_pwr,
    output sqw_pkg::sq_state_e  state_o
);
    import sqw_pkg::*;

    sq_state_e state_d;

    always_comb begin
        if (!main_pwr) begin
            if (out_en && full_rate && aux_bat_en && aux_pwr) state_d = SQ_BATT_REF;
            else                                              state_d = SQ_BATT_BLOCK;
        end else if (!out_en) begin
            state_d = SQ_DISABLED;
        end else if (full_rate) begin
            state_d = SQ_REF;
        end else if (rate_zero) begin
            state_d = SQ_NO_RATE;
        end else begin
            state_d = SQ_TAP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= SQ_DISABLED;
        else        state_o <= state_d;
    end
endmodule

// File: rtl/sqw_gen.sv
`timescale 1ns/1ps
module sqw_gen #(
    parameter int CNT_W = 15,
    parameter int RS_W  = 4,
    parameter int DV_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_tick,
    input  logic            out_en,
    input  logic            full_rate,
    input  logic [RS_W-1:0] rate_sel,
    input  logic [DV_W-1:0] run_ctl,
    input  logic            main_pwr,
    input  logic            aux_bat_en,
    input  logic            aux_pwr,
    output logic            sq_out
);
    import sqw_pkg::*;

    logic             ref_ph;
    logic [CNT_W-1:0] count;
    logic             tap_bit;
    logic             chain_run;
    sq_state_e        state_q;

    assign chain_run = !run_ctl[2] && run_ctl[1];

    sqw_ref_phase u_phase (
        .clk(clk), .rst_n(rst_n), .tick_i(edge_tick), .phase_o(ref_ph)
    );

    sqw_div_chain #(.CNT_W(CNT_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .tick_i(edge_tick),
        .run_i(chain_run), .count_o(count)
    );

    sqw_tap_mux #(.CNT_W(CNT_W), .RS_W(RS_W)) u_mux (
        .count_i(count), .code_i(rate_sel), .tap_o(tap_bit)
    );

    sqw_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .full_rate(full_rate),
        .rate_zero(rate_sel == '0), .main_pwr(main_pwr),
        .aux_bat_en(aux_bat_en), .aux_pwr(aux_pwr), .state_o(state_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_out <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_REF, SQ_BATT_REF: sq_out <= ref_ph;
                SQ_TAP:              sq_out <= tap_bit;
                default:             sq_out <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sqw_gen_chk.sv
`timescale 1ns/1ps
module sqw_gen_chk #(
    parameter int CNT_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               out_en,
    input logic               full_rate,
    input logic [2:0]         run_ctl,
    input logic               main_pwr,
    input logic               aux_bat_en,
    input logic               aux_pwr,
    input logic               sq_out,
    input sqw_pkg::sq_state_e state,
    input logic [CNT_W-1:0]   cnt,
    input logic               phase
);
    import sqw_pkg::*;

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DISABLED || state == SQ_NO_RATE) |=> !sq_out); // R2

    AST_REF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_REF) |=> (sq_out == $past(phase))); // R3

    AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!run_ctl[2] && run_ctl[1]) |=> (cnt == '0)); // R6

    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ctl[2] && run_ctl[1] && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase != $past(phase))); // R7

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase)); // R7

    AST_BATT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr && !(out_en && full_rate && aux_bat_en && aux_pwr))
        |=> (state == SQ_BATT_BLOCK)); // R8

    AST_BATT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BATT_BLOCK) |=> !sq_out); // R8
endmodule

bind sqw_gen sqw_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(edge_tick), .out_en(out_en),
    .full_rate(full_rate), .run_ctl(run_ctl), .main_pwr(main_pwr),
    .aux_bat_en(aux_bat_en), .aux_pwr(aux_pwr), .sq_out(sq_out),
    .state(state_q), .cnt(count), .phase(ref_ph)
);

// File: tb/sqw_gen_bench.sv
`timescale 1ns/1ps
module sqw_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_tick = 1'b0;
    logic       out_en = 1'b0, full_rate = 1'b0, main_pwr = 1'b1;
    logic       aux_bat_en = 1'b0, aux_pwr = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic [2:0] run_ctl = 3'b010;
    logic       sq_out;

    int    checks = 0, errors = 0, cyc = 0;
    bit    comparing = 1'b0;
    string cur_req = "R1";

    int m_ref, m_cnt, m_mode;
    bit m_out;

    always #2.5 clk = ~clk;

    sqw_gen u_sqw_gen (
        .clk(clk), .rst_n(rst_n), .edge_tick(edge_tick), .out_en(out_en),
        .full_rate(full_rate), .rate_sel(rate_sel), .run_ctl(run_ctl),
        .main_pwr(main_pwr), .aux_bat_en(aux_bat_en), .aux_pwr(aux_pwr),
        .sq_out(sq_out)
    );

    // Divided frequency in Hz for a rate code, from the requirements.
    function automatic int freq_of(input int code);
        if (code == 1) return 256;
        if (code == 2) return 128;
        return 8192 >> (code - 3);
    endfunction

    function automatic int bit_of(input int code);
        int f;
        int k = 0;
        if (code == 0) return 99;
        f = freq_of(code);
        while ((32768 >> k) > f) k++;
        return k;
    endfunction

    // 0 = low, 1 = reference, 2 = divided
    function automatic int mode_of();
        if (!main_pwr) return (out_en && full_rate && aux_bat_en && aux_pwr) ? 1 : 0;
        if (!out_en) return 0;
        if (full_rate) return 1;
        if (rate_sel == 0) return 0;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref <= 0; m_cnt <= 0; m_mode <= 0; m_out <= 1'b0;
        end else begin
            if (m_mode == 1)      m_out <= m_ref[0];
            else if (m_mode == 2) m_out <= ((m_cnt >> bit_of(int'(rate_sel))) & 1) != 0;
            else                  m_out <= 1'b0;
            if (edge_tick) m_ref <= 1 - m_ref;
            if (!(run_ctl[2] == 1'b0 && run_ctl[1] == 1'b1)) m_cnt <= 0;
            else if (edge_tick) m_cnt <= (m_cnt + 1) % 32768;
            m_mode <= mode_of();
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (rst_n && comparing) check(cur_req, int'(sq_out), int'(m_out), "sq_out vs model");
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL %s watchdog: actual %0d cycles expected below 150000", cur_req, cyc);
            finish_run();
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            edge_tick = ~edge_tick;
        end
    end

    task automatic run(input string req, input int n);
        cur_req = req;
        repeat (n) @(negedge clk);
    endtask

    task automatic setm(input bit oe, input bit fr, input int rs, input int dv,
                        input bit mp, input bit abe, input bit ap);
        out_en = oe; full_rate = fr; rate_sel = 4'(rs); run_ctl = 3'(dv);
        main_pwr = mp; aux_bat_en = abe; aux_pwr = ap;
    endtask

    initial begin
        int tg;
        bit prev;
        repeat (4) @(negedge clk);
        check("R1", int'(sq_out), 0, "output in reset");
        rst_n = 1'b1;
        comparing = 1'b1;

        setm(0, 1, 3, 3'b010, 1, 1, 1); run("R2", 200);
        setm(0, 0, 5, 3'b010, 1, 0, 0); run("R2", 100);

        setm(0, 1, 5, 3'b010, 1, 0, 0); run("R9", 4);
        out_en = 1'b1;
        @(negedge clk);
        check("R9", int'(sq_out), 0, "output one cycle after enable");
        run("R3", 10);
        tg = 0; prev = sq_out;
        repeat (100) begin
            @(negedge clk);
            if (sq_out != prev) tg++;
            prev = sq_out;
        end
        check("R3", tg, 50, "reference toggles in 100 cycles");
        rate_sel = 4'd0; run("R3", 100);
        rate_sel = 4'd15; run("R3", 100);

        for (int c = 1; c < 16; c++) begin
            setm(1, 0, c, 3'b010, 1, 0, 0); run("R4", 600);
        end
        rate_sel = 4'd3; run("R9", 50);
        rate_sel = 4'd4; run("R9", 50);

        setm(1, 0, 0, 3'b010, 1, 0, 0); run("R5", 200);

        for (int d = 0; d < 8; d++) begin
            setm(1, 0, 3, d, 1, 0, 0); run("R6", 150);
        end
        setm(1, 0, 3, 3'b011, 1, 0, 0); run("R6", 300);

        setm(1, 1, 3, 3'b000, 1, 0, 0); run("R7", 200);
        setm(1, 1, 3, 3'b111, 1, 0, 0); run("R7", 100);

        setm(1, 1, 3, 3'b010, 0, 1, 1); run("R8", 200);
        setm(0, 1, 3, 3'b010, 0, 1, 1); run("R8", 100);
        setm(1, 0, 3, 3'b010, 0, 1, 1); run("R8", 100);
        setm(1, 1, 3, 3'b010, 0, 0, 1); run("R8", 100);
        setm(1, 1, 3, 3'b010, 0, 1, 0); run("R8", 100);
        setm(1, 1, 3, 3'b010, 0, 1, 1); run("R8", 100);

        setm(1, 0, 15, 3'b010, 1, 0, 0); run("R4", 34000);

        finish_run();
    end
endmodule